// File: doc/BRIEF.md
# Reloadable System Timer with Free-Running Timestamp

This unit gives a processor two time sources behind one small register bus. The first is a 32-bit timestamp that advances by one on every clock and wraps freely. Software reads it as a monotonic tick count and may overwrite it, usually with zero. The second is a down-counter that raises an interrupt when it runs out. It can re-arm itself for a periodic tick, or stop after one expiry to serve as an event timer.

The down-counter is programmed through a single reload word. The two lowest bits of that word are option flags and the upper bits are the count. Bit 0 is the run enable and bit 1 selects one-shot. The count field is the word with bits [1:0] forced to zero. Each expiry sets a sticky pending flag that drives the interrupt output. Software clears the flag by writing 1 to it.

The down-counter is a three-state machine:
- IDLE: the count holds.
- RUN: the count decrements once per cycle.
- DONE: a one-shot has expired and the count holds at zero.

The transitions are:
- IDLE→RUN or DONE→RUN: a reload write with the enable bit set.
- RUN→IDLE or DONE→IDLE: a reload write with the enable bit clear. This includes a write of all zeros.
- RUN→DONE: expiry while the one-shot bit is set.
- RUN→RUN on expiry: periodic re-arm.

Register map (2-bit word address):

| Address | Name | Access | Content |
|---------|------|--------|---------|
| 0 | stamp | read/write | timestamp |
| 1 | reload | read/write | reload word |
| 2 | count | read only | current down-count |
| 3 | status | read / write-1-to-clear | pending flag in bit 0 |

Top module: `os_timer_unit`

## Requirements
- R1: While reset is asserted and right after it, every register reads zero, `irq` is low, and the down-counter is in IDLE.
- R2: With no write to address 0, the timestamp increases by exactly one every clock and wraps from 0xFFFFFFFF to 0.
- R3: A write to address 0 loads the written value into the timestamp on that edge. Counting resumes from that value on the next edge, so writing 0 resets it.
- R4: A write to address 1 stores the full word, which reads back unchanged. On the same edge it loads the down-counter with the word's bits [1:0] cleared. Writes to address 2 are ignored.
- R5: With bit 0 = 1 and bit 1 = 0, the counter decrements once per cycle. In the cycle where it holds zero it expires. It then sets pending and reloads the count field. The period is therefore (count field + 1) cycles.
- R6: With bit 0 = 1 and bit 1 = 1, the first expiry sets pending, moves to DONE and leaves the count at zero. No further expiry follows.
- R7: With bit 0 = 0, the counter holds its value and never expires.
- R8: Writing 0 to address 1 stops the timer and sets the count to zero.
- R9: Writing a 1 in bit 0 of address 3 clears pending, and writing 0 there leaves it unchanged. An expiry in the same cycle as a clear wins, so pending ends up set. A reload write in the cycle the counter would expire pre-empts that expiry.
- R10: `irq` is high exactly while the pending flag (address 3, bit 0) is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the addressed register |
| reg_addr | input | 2 | Word address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq | output | 1 | Interrupt request, high while pending |

## Verification
The bench aims at the following corner cases:
- **Timestamp wrap.** A counter that saturated or skipped would diverge from the reference right after 0xFFFFFFFF.
- **Period length.** A counter that reloaded one cycle early would shorten every period by one cycle.
- **One-shot.** A one-shot that re-armed would raise pending again after the first expiry.
- **Clear colliding with an expiry.** The timer is programmed with a zero count so that it expires every cycle. A clear then lands on an expiry; if the clear won, the interrupt would be lost.
- **Ignored writes.** A clear with bit 0 = 0, and a write to the read-only count register, must both leave the state unchanged.

// File: rtl/ostmr_pkg.sv
package ostmr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } tmr_state_e;

    localparam logic [1:0] ADDR_STAMP  = 2'd0;
    localparam logic [1:0] ADDR_RELOAD = 2'd1;
    localparam logic [1:0] ADDR_COUNT  = 2'd2;
    localparam logic [1:0] ADDR_STATUS = 2'd3;

    localparam int OPT_W       = 2;
    localparam int OPT_EN_BIT  = 0;
    localparam int OPT_ONE_BIT = 1;

endpackage

// File: rtl/ostmr_stamp.sv
module ostmr_stamp #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] stamp
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stamp <= '0;
        end else if (load) begin
            stamp <= load_val;
        end else begin
            stamp <= stamp + W'(1);
        end
    end

    // R2: free-running increment with wrap
    a_r2_stamp_inc : assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> stamp == $past(stamp) + W'(1));

    // R3: software load
    a_r3_stamp_load : assert property (@(posedge clk) disable iff (!rst_n)
        load |=> stamp == $past(load_val));

endmodule

// File: rtl/ostmr_down.sv
module ostmr_down
    import ostmr_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         clr_pend,
    output logic [W-1:0] reload_word,
    output logic [W-1:0] count,
    output logic         pending
);

    localparam logic [W-1:0] CNT_MASK = {{(W-OPT_W){1'b1}}, {OPT_W{1'b0}}};

    tmr_state_e state_q, state_d;
    logic [W-1:0] reload_q, cnt_q;
    logic pend_q;
    logic one_shot, expire, load_en;

    assign one_shot = reload_q[OPT_ONE_BIT];
    assign load_en  = load && load_val[OPT_EN_BIT];
    assign expire   = (state_q == ST_RUN) && (cnt_q == '0) && !load;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (load_en) state_d = ST_RUN;
            ST_RUN: begin
                if (load)                    state_d = load_en ? ST_RUN : ST_IDLE;
                else if (expire && one_shot) state_d = ST_DONE;
            end
            ST_DONE: if (load)               state_d = load_en ? ST_RUN : ST_IDLE;
            default:                         state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reload_q <= '0;
            cnt_q    <= '0;
            pend_q   <= 1'b0;
        end else begin
            if (load) begin
                reload_q <= load_val;
                cnt_q    <= load_val & CNT_MASK;
            end else if (expire) begin
                cnt_q    <= one_shot ? cnt_q : (reload_q & CNT_MASK);
            end else if (state_q == ST_RUN) begin
                cnt_q    <= cnt_q - W'(1);
            end

            if (expire)        pend_q <= 1'b1;
            else if (clr_pend) pend_q <= 1'b0;
        end
    end

    assign reload_word = reload_q;
    assign count       = cnt_q;
    assign pending     = pend_q;

    // R7: idle counter holds
    a_r7_idle_hold : assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) && !load |=> $stable(cnt_q));

    // R6: expired one-shot stays at zero
    a_r6_done_hold : assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE) && !load |=> (cnt_q == '0) && (state_q == ST_DONE));

    // R8: zero write stops and clears
    a_r8_zero_write : assert property (@(posedge clk) disable iff (!rst_n)
        load && (load_val == '0) |=> (cnt_q == '0) && (state_q == ST_IDLE));

    // R5: periodic re-arm picks up the count field
    a_r5_rearm : assert property (@(posedge clk) disable iff (!rst_n)
        expire && !one_shot |=> cnt_q == ($past(reload_q) & CNT_MASK));

    // R9: clear without a colliding expiry drops the flag
    a_r9_clear : assert property (@(posedge clk) disable iff (!rst_n)
        clr_pend && !expire |=> !pend_q);

    // R9: expiry always leaves the flag set
    a_r9_set_wins : assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> pend_q);

endmodule

// File: rtl/os_timer_unit.sv
module os_timer_unit
    import ostmr_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         reg_wr,
    input  logic [1:0]   reg_addr,
    input  logic [W-1:0] reg_wdata,
    output logic [W-1:0] reg_rdata,
    output logic         irq
);

    logic [W-1:0] stamp, reload_word, count;
    logic pending;
    logic wr_stamp, wr_reload, clr_pend;

    assign wr_stamp  = reg_wr && (reg_addr == ADDR_STAMP);
    assign wr_reload = reg_wr && (reg_addr == ADDR_RELOAD);
    assign clr_pend  = reg_wr && (reg_addr == ADDR_STATUS) && reg_wdata[0];

    ostmr_stamp #(.W(W)) u_stamp (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (wr_stamp),
        .load_val (reg_wdata),
        .stamp    (stamp)
    );

    ostmr_down #(.W(W)) u_down (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (wr_reload),
        .load_val    (reg_wdata),
        .clr_pend    (clr_pend),
        .reload_word (reload_word),
        .count       (count),
        .pending     (pending)
    );

    always_comb begin
        unique case (reg_addr)
            ADDR_STAMP:  reg_rdata = stamp;
            ADDR_RELOAD: reg_rdata = reload_word;
            ADDR_COUNT:  reg_rdata = count;
            ADDR_STATUS: reg_rdata = {{(W-1){1'b0}}, pending};
            default:     reg_rdata = '0;
        endcase
    end

    assign irq = pending;

    // R10: interrupt follows the status bit seen on the bus
    a_r10_irq_status : assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADDR_STATUS) |-> irq == reg_rdata[0]);

endmodule

// File: tb/os_timer_unit_tb.sv
module os_timer_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int n_chk = 0;
    int n_err = 0;
    string phase = "R1";

    // reference model state
    logic [31:0] m_ts = '0, m_rl = '0, m_cnt = '0;
    int          m_st = 0;      // 0 idle, 1 run, 2 done
    bit          m_pend = 1'b0;

    always #4 clk = ~clk;

    os_timer_unit u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq       (irq)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ts = '0; m_rl = '0; m_cnt = '0; m_st = 0; m_pend = 1'b0;
        end else begin
            bit exp_now;
            exp_now = 1'b0;
            if (reg_wr && reg_addr == 2'd0) m_ts = reg_wdata;
            else                            m_ts = m_ts + 32'd1;
            if (reg_wr && reg_addr == 2'd1) begin
                m_rl  = reg_wdata;
                m_cnt = {reg_wdata[31:2], 2'b00};
                m_st  = reg_wdata[0] ? 1 : 0;
            end else if (m_st == 1) begin
                if (m_cnt == 0) begin
                    exp_now = 1'b1;
                    if (m_rl[1]) m_st = 2;
                    else         m_cnt = {m_rl[31:2], 2'b00};
                end else begin
                    m_cnt = m_cnt - 32'd1;
                end
            end
            if (exp_now) m_pend = 1'b1;
            else if (reg_wr && reg_addr == 2'd3 && reg_wdata[0]) m_pend = 1'b0;
        end
    end

    function automatic logic [31:0] model_read(input logic [1:0] a);
        case (a)
            2'd0:    return m_ts;
            2'd1:    return m_rl;
            2'd2:    return m_cnt;
            default: return {31'd0, m_pend};
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            check({phase, " rdata"}, reg_rdata, model_read(reg_addr));
            check({phase, " R10 irq"}, {31'd0, irq}, {31'd0, m_pend});
        end
    end

    task automatic step();
        @(negedge clk); #2;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        step();
        reg_wr = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            reg_addr = 2'(i % 4);
            step();
        end
    endtask

    initial begin
        #(8 * 200000);
        n_err++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        // R1: reset state on every address
        #2;
        for (int a = 0; a < 4; a++) begin
            reg_addr = 2'(a);
            step();
            check("R1 reset read", reg_rdata, 32'd0);
        end
        check("R1 reset irq", {31'd0, irq}, 32'd0);
        rst_n = 1'b1;
        step();

        phase = "R2 count";      idle(12);
        phase = "R2 wrap";       wr(2'd0, 32'hFFFF_FFFD); reg_addr = 2'd0; idle(1); step(); step(); step();
        phase = "R3 zero";       wr(2'd0, 32'd0); idle(6);
        phase = "R4 R7 hold";    wr(2'd1, 32'h0000_002A); idle(10);
        reg_addr = 2'd2; step();
        check("R7 count held", reg_rdata, 32'h0000_0028);
        reg_addr = 2'd1; step();
        check("R4 reload readback", reg_rdata, 32'h0000_002A);
        phase = "R4 ro write";   wr(2'd2, 32'h55); idle(4);
        phase = "R5 periodic";   wr(2'd1, 32'h0000_0015); idle(50);
        phase = "R9 clr0";       wr(2'd3, 32'h0); idle(2);
        phase = "R9 clr1";       wr(2'd3, 32'h1); idle(3);
        phase = "R9 collide";    wr(2'd1, 32'h0000_0001); idle(3);
        wr(2'd3, 32'h1);
        reg_addr = 2'd3; step();
        check("R9 expiry beats clear", reg_rdata, 32'd1);
        phase = "R6 oneshot";    wr(2'd1, 32'h0000_0013); wr(2'd3, 32'h1); idle(30);
        check("R6 pending once", {31'd0, irq}, 32'd1);
        wr(2'd3, 32'h1); idle(20);
        reg_addr = 2'd2; step();
        check("R6 count stays zero", reg_rdata, 32'd0);
        check("R6 no re-fire", {31'd0, irq}, 32'd0);
        phase = "R8 stop";       wr(2'd1, 32'h0000_0031); idle(5);
        wr(2'd1, 32'd0); idle(8);
        reg_addr = 2'd2; step();
        check("R8 count zero", reg_rdata, 32'd0);

        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule